// File: doc/BRIEF.md
# Pipelined No-Wait Synchronous SRAM

A single-clock synchronous memory whose address, control and write data all pass through registers, and whose read and write accesses may alternate on every clock with no turnaround cycle. A read delivers its word into an output register one enabled clock after the address is accepted. A write takes its data two enabled clocks after its address, so the data of an earlier write and the address of a later read share the same cycle without conflict.

Each access can start a four-beat burst. When the continue input is high, the operation in progress moves on to the next address: read, write or deselect alike. The burst order is linear or interleaved and is set by a static mode input. Writes are masked per byte lane, and a write with every lane masked is aborted. A hold input freezes the whole pipeline, including the output register. The drive output tells the pad logic when the data bus is driven. In every other cycle the bus is high-impedance.

Top module: `nowait_sram`

## Requirements
- R1: A new access starts only when `cont`=0 at an enabled edge. The part is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A new access that is not selected is a deselect: it drives no data and writes nothing.
- R2: A new selected access with `wr_n`=1 and at least one `lane_n` bit low is a read. At the next enabled edge the output register loads the word, and `rd_drive` rises when `drive_n`=0.
- R3: A new selected access with `wr_n`=0 is a write. The data on `wr_data` at the second enabled edge after the address edge is stored.
- R4: On a write, lane i (bits 8i+7..8i) is stored only when `lane_n[i]`=0, sampled with the address. All `lane_n` bits high makes the write an abort, and the array is left unchanged.
- R5: A new selected access with `wr_n`=1 and all `lane_n` bits high is a dummy read. It drives nothing and leaves the array unchanged.
- R6: With `burst_interleave`=0, beat k of a burst from base address b uses low address bits (b+k) mod 4. The upper address bits stay fixed.
- R7: With `burst_interleave`=1, beat k uses low address bits b XOR k.
- R8: `cont`=1 continues the current operation at the next burst address, and `wr_n` and the select inputs are ignored. A continued deselect stays deselected. A continued write takes `lane_n` afresh on each beat.
- R9: While `hold`=1, all synchronous inputs are ignored, no register changes, and the output holds its value and its drive state.
- R10: `rd_drive` is high only when `drive_n`=0 and the last enabled edge loaded read data. It is low after reset and during write, deselect and dummy cycles.
- R11: A read accepted one enabled edge after a write to the same address returns the data of that write in the lanes it writes, and the stored word in the other lanes.
- R12: Reads and writes may alternate on consecutive enabled edges with no idle cycle, and each returns or stores the correct word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hold | input | 1 | Suspend: freezes all registers when high |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| cont | input | 1 | High: continue burst; low: new access |
| wr_n | input | 1 | Low: write, high: read |
| lane_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| burst_interleave | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| drive_n | input | 1 | Output enable, active low |
| wr_data | input | LANES*LANE_W | Write data, two enabled clocks after the address |
| rd_data | output | LANES*LANE_W | Output register |
| rd_drive | output | 1 | High when the data bus is driven, low for high-impedance |

## Verification
A wrong select decode or operation state shows on `rd_drive` at the enabled edge after the faulty address cycle. It shows up as a driven bus during a write or deselect, or as a silent bus on a read. A late-write pipeline that is off by one stage, or a wrong byte mask, shows only when the word is read back. For that reason each write is followed by a read of its address, and the read-right-after-write case exposes a missing forward path within two cycles. A burst counter fault shows as a wrong word on the second beat, and a hold that leaks shows as `rd_data` or `rd_drive` changing during the suspended cycle.

// File: rtl/nowait_sram_burst.sv
module nowait_sram_burst #(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        step,
  input  logic              interleave,
  output logic [ADDR_W-1:0] addr
);
  logic [1:0] lo;
  assign lo   = interleave ? (base[1:0] ^ step) : (base[1:0] + step);
  assign addr = {base[ADDR_W-1:2], lo};
endmodule

// File: rtl/nowait_sram.sv
module nowait_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hold,
  input  logic                     sel_a_n,
  input  logic                     sel_b,
  input  logic                     sel_c_n,
  input  logic                     cont,
  input  logic                     wr_n,
  input  logic [LANES-1:0]         lane_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     burst_interleave,
  input  logic                     drive_n,
  input  logic [LANES*LANE_W-1:0]  wr_data,
  output logic [LANES*LANE_W-1:0]  rd_data,
  output logic                     rd_drive
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [1:0] {OP_IDLE, OP_RD, OP_DUMMY, OP_WR} op_t;

  op_t               op_q, op_nx;
  logic [1:0]        cnt_q, cnt_nx;
  logic [ADDR_W-1:0] base_q, eff_addr;
  logic              sel;

  logic              s1_rd, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_mask;
  logic              s2_wr;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_mask;

  logic              out_rd;
  logic [DATA_W-1:0] q_r, merged;
  logic              fwd_hit;
  logic [DATA_W-1:0] mem [DEPTH];

  assign sel = !sel_a_n && sel_b && !sel_c_n;

  always_comb begin
    op_nx  = op_q;
    cnt_nx = cnt_q + 2'd1;
    if (!cont) begin
      cnt_nx = 2'd0;
      if (!sel)      op_nx = OP_IDLE;
      else if (wr_n) op_nx = (&lane_n) ? OP_DUMMY : OP_RD;
      else           op_nx = OP_WR;
    end
  end

  nowait_sram_burst #(.ADDR_W(ADDR_W)) i_burst (
    .base       (cont ? base_q : addr),
    .step       (cnt_nx),
    .interleave (burst_interleave),
    .addr       (eff_addr)
  );

  assign fwd_hit = s2_wr && (s2_addr == s1_addr);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i*LANE_W +: LANE_W] = (fwd_hit && s2_mask[i]) ?
           wr_data[i*LANE_W +: LANE_W] : mem[s1_addr][i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst_n && !hold && s2_wr)
      for (int i = 0; i < LANES; i++)
        if (s2_mask[i]) mem[s2_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
      s1_rd   <= 1'b0;
      s1_wr   <= 1'b0;
      s1_addr <= '0;
      s1_mask <= '0;
      s2_wr   <= 1'b0;
      s2_addr <= '0;
      s2_mask <= '0;
      out_rd  <= 1'b0;
      q_r     <= '0;
    end else if (!hold) begin
      op_q    <= op_nx;
      cnt_q   <= cnt_nx;
      if (!cont) base_q <= addr;
      s1_rd   <= (op_nx == OP_RD);
      s1_wr   <= (op_nx == OP_WR);
      s1_addr <= eff_addr;
      s1_mask <= ~lane_n;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_mask <= s1_mask;
      out_rd  <= s1_rd;
      if (s1_rd) q_r <= merged;
    end
  end

  assign rd_data  = q_r;
  assign rd_drive = out_rd && !drive_n;

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && hold) |=> ($stable(q_r) && $stable(out_rd))); // R9
  AST_READ_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !hold && !cont && sel && wr_n && !(&lane_n)) ##1 !hold |=> out_rd); // R2
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !hold && !cont && sel && !wr_n) ##1 !hold |=> !out_rd); // R10
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !hold && !cont && !sel) ##1 !hold |=> !out_rd); // R1
  AST_DUMMY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !hold && !cont && sel && wr_n && (&lane_n)) ##1 !hold |=> !out_rd); // R5
  AST_DESEL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !hold && cont && op_q == OP_IDLE) |=> (op_q == OP_IDLE)); // R8
endmodule

// File: tb/test_nowait_sram.sv
module test_nowait_sram;
  logic        clk = 1'b0;
  logic        rst_n, hold, sel_a_n, sel_b, sel_c_n, cont, wr_n, burst_interleave, drive_n;
  logic [3:0]  lane_n;
  logic [5:0]  addr;
  logic [31:0] wr_data, rd_data;
  logic        rd_drive;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [31:0] ref_mem [64];

  localparam logic [2:0] SEL = 3'b010;
  localparam logic [2:0] DES = 3'b110;

  always #10 clk = ~clk;

  nowait_sram i_nowait_sram (
    .clk(clk), .rst_n(rst_n), .hold(hold), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .cont(cont), .wr_n(wr_n), .lane_n(lane_n), .addr(addr),
    .burst_interleave(burst_interleave), .drive_n(drive_n), .wr_data(wr_data),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  task automatic tick(input logic [2:0] ce, input logic a, input logic w,
                      input logic [3:0] b, input logic [5:0] ad, input logic [31:0] d);
    {sel_a_n, sel_b, sel_c_n} = ce;
    cont = a; wr_n = w; lane_n = b; addr = ad; wr_data = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic drv_exp, input logic [31:0] q_exp, input bit cmp_q);
    total++;
    if (rd_drive !== drv_exp || (cmp_q && rd_data !== q_exp)) begin
      bad++;
      $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h", tag, rd_drive, rd_data, drv_exp, q_exp);
    end
  endtask

  task automatic model_wr(input logic [5:0] ad, input logic [31:0] d, input logic [3:0] b);
    for (int i = 0; i < 4; i++)
      if (!b[i]) ref_mem[ad][i*8 +: 8] = d[i*8 +: 8];
  endtask

  task automatic wr_word(input logic [5:0] ad, input logic [31:0] d, input logic [3:0] b);
    tick(SEL, 1'b0, 1'b0, b, ad, 32'h0);
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h0);
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, d);
    model_wr(ad, d, b);
  endtask

  task automatic rd_chk(input logic [5:0] ad, input string tag);
    tick(SEL, 1'b0, 1'b1, 4'h0, ad, 32'h0);
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h0);
    chk(tag, 1'b1, ref_mem[ad], 1'b1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; hold = 1'b0; drive_n = 1'b0; burst_interleave = 1'b0;
    for (int i = 0; i < 3; i++) tick(SEL, 1'b0, 1'b1, 4'h0, 6'd0, 32'h0);
    chk("R10 reset drive low", 1'b0, 32'h0, 1'b0);
    rst_n = 1'b1;
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h0);
    chk("R10 after reset", 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_basic;
    wr_word(6'd5, 32'h11223344, 4'h0);
    rd_chk(6'd5, "R2 R3 full word");
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h0);
    chk("R10 deselect after read", 1'b0, 32'h0, 1'b0);
    wr_word(6'd5, 32'hAAAAAAAA, 4'b1010);
    rd_chk(6'd5, "R4 lane mask");
    wr_word(6'd5, 32'hFFFFFFFF, 4'hF);
    rd_chk(6'd5, "R4 write abort");
  endtask

  task automatic t_dummy_desel;
    logic [2:0] pats [3] = '{3'b110, 3'b000, 3'b011};
    tick(SEL, 1'b0, 1'b1, 4'hF, 6'd5, 32'h0);
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h0);
    chk("R5 dummy read no drive", 1'b0, 32'h0, 1'b0);
    rd_chk(6'd5, "R5 dummy leaves array");
    for (int p = 0; p < 3; p++) begin
      tick(pats[p], 1'b0, 1'b1, 4'h0, 6'd5, 32'h0);
      tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h0);
      chk("R1 unselected read", 1'b0, 32'h0, 1'b0);
      tick(pats[p], 1'b0, 1'b0, 4'h0, 6'd5, 32'h0);
      tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h0);
      tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'hFFFFFFFF);
      rd_chk(6'd5, "R1 unselected write ignored");
    end
  endtask

  task automatic t_burst_read(input logic mode, input logic [5:0] start, input string tag);
    burst_interleave = mode;
    tick(SEL, 1'b0, 1'b1, 4'h0, start, 32'h0);
    for (int k = 0; k < 4; k++) begin
      logic [1:0] lo;
      lo = mode ? (start[1:0] ^ 2'(k)) : (start[1:0] + 2'(k));
      if (k < 3) tick(SEL, 1'b1, 1'b0, 4'h0, 6'd0, 32'h0);
      else       tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h0);
      chk(tag, 1'b1, ref_mem[{start[5:2], lo}], 1'b1);
    end
    burst_interleave = 1'b0;
  endtask

  task automatic t_bursts;
    for (int i = 0; i < 4; i++) wr_word(6'(8 + i), 32'h100 + 32'(i), 4'h0);
    t_burst_read(1'b0, 6'd10, "R6 linear burst read");
    t_burst_read(1'b1, 6'd9, "R7 interleaved burst read");
    wr_word(6'd16, 32'h0, 4'h0);
    tick(SEL, 1'b0, 1'b0, 4'h0, 6'd18, 32'h0);
    tick(DES, 1'b1, 1'b1, 4'h0, 6'd0, 32'h0);
    tick(DES, 1'b1, 1'b1, 4'b1110, 6'd0, 32'hD0D0D0D0);
    tick(DES, 1'b1, 1'b1, 4'h0, 6'd0, 32'hD1D1D1D1);
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h33333333);
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'hD3D3D3D3);
    model_wr(6'd18, 32'hD0D0D0D0, 4'h0);
    model_wr(6'd19, 32'hD1D1D1D1, 4'h0);
    model_wr(6'd16, 32'h33333333, 4'b1110);
    model_wr(6'd17, 32'hD3D3D3D3, 4'h0);
    rd_chk(6'd18, "R8 burst write beat0");
    rd_chk(6'd19, "R8 burst write beat1");
    rd_chk(6'd16, "R8 burst write masked beat2");
    rd_chk(6'd17, "R8 burst write beat3");
    wr_word(6'd21, 32'h21212121, 4'h0);
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd20, 32'h0);
    tick(SEL, 1'b1, 1'b0, 4'h0, 6'd0, 32'h0);
    chk("R8 continued deselect", 1'b0, 32'h0, 1'b0);
    tick(SEL, 1'b1, 1'b1, 4'h0, 6'd0, 32'h0);
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h5A5A5A5A);
    chk("R8 continued deselect no read", 1'b0, 32'h0, 1'b0);
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h5A5A5A5A);
    rd_chk(6'd21, "R8 continued deselect no write");
  endtask

  task automatic t_hold;
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h0);
    tick(SEL, 1'b0, 1'b1, 4'h0, 6'd5, 32'h0);
    hold = 1'b1;
    tick(SEL, 1'b0, 1'b1, 4'h0, 6'd8, 32'h0);
    chk("R9 suspended before output", 1'b0, 32'h0, 1'b0);
    hold = 1'b0;
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h0);
    chk("R9 read resumes", 1'b1, ref_mem[5], 1'b1);
    hold = 1'b1;
    tick(SEL, 1'b0, 1'b0, 4'h0, 6'd5, 32'hDEADBEEF);
    chk("R9 output held driven", 1'b1, ref_mem[5], 1'b1);
    tick(SEL, 1'b0, 1'b1, 4'h0, 6'd9, 32'hDEADBEEF);
    chk("R9 output held second cycle", 1'b1, ref_mem[5], 1'b1);
    hold = 1'b0;
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'hDEADBEEF);
    chk("R9 released", 1'b0, 32'h0, 1'b0);
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'hDEADBEEF);
    rd_chk(6'd5, "R9 suspended write ignored");
    tick(SEL, 1'b0, 1'b0, 4'h0, 6'd30, 32'h0);
    hold = 1'b1;
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h0BAD0BAD);
    hold = 1'b0;
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h0BAD0BAD);
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h30303030);
    model_wr(6'd30, 32'h30303030, 4'h0);
    rd_chk(6'd30, "R9 write data after suspend");
  endtask

  task automatic t_oe;
    tick(SEL, 1'b0, 1'b1, 4'h0, 6'd5, 32'h0);
    drive_n = 1'b1;
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h0);
    chk("R10 output disabled", 1'b0, 32'h0, 1'b0);
    drive_n = 1'b0;
    #1;
    chk("R10 output enabled", 1'b1, ref_mem[5], 1'b1);
  endtask

  task automatic t_forward;
    wr_word(6'd40, 32'h01020304, 4'h0);
    tick(SEL, 1'b0, 1'b0, 4'b0011, 6'd40, 32'h0);
    tick(SEL, 1'b0, 1'b1, 4'h0, 6'd40, 32'h0);
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'hAABBCCDD);
    model_wr(6'd40, 32'hAABBCCDD, 4'b0011);
    chk("R11 forwarded merge", 1'b1, ref_mem[40], 1'b1);
    rd_chk(6'd40, "R11 stored merge");
  endtask

  task automatic t_b2b;
    tick(SEL, 1'b0, 1'b0, 4'h0, 6'd44, 32'h0);
    tick(SEL, 1'b0, 1'b1, 4'h0, 6'd5, 32'h0);
    tick(SEL, 1'b0, 1'b0, 4'h0, 6'd45, 32'h44444444);
    chk("R12 read between writes", 1'b1, ref_mem[5], 1'b1);
    tick(SEL, 1'b0, 1'b1, 4'h0, 6'd40, 32'h0);
    chk("R12 write slot not driven", 1'b0, 32'h0, 1'b0);
    tick(DES, 1'b0, 1'b1, 4'hF, 6'd0, 32'h45454545);
    chk("R12 second read", 1'b1, ref_mem[40], 1'b1);
    model_wr(6'd44, 32'h44444444, 4'h0);
    model_wr(6'd45, 32'h45454545, 4'h0);
    rd_chk(6'd44, "R12 first write stored");
    rd_chk(6'd45, "R12 second write stored");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = 32'h0;
    @(negedge clk);
    t_reset;
    t_basic;
    t_dummy_desel;
    t_bursts;
    t_hold;
    t_oe;
    t_forward;
    t_b2b;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule